// File: doc/BRIEF.md
# Indexed NVRAM Access Port

This block puts a byte-wide non-volatile-style RAM behind a four-byte I/O window. The host never sees the RAM directly: it first loads a 16-bit location pointer in two byte-sized halves through two window offsets, then moves one data byte through a third offset. A data write stores the byte and returns the pointer to zero, so the next transfer needs a fresh pointer unless location zero is wanted. A data read leaves the pointer where it was.

Two protection bits guard two fixed 16-byte stretches near the bottom of the space. Protection bit 0 covers 0x20..0x2F and bit 1 covers 0x30..0x3F. A protected location drops writes and reads back as 0xFF. Each protection bit flips when a one-cycle toggle pulse names it. Pointer values at or above the RAM size behave like a protected location. Reset clears the pointer and both protection bits and leaves the RAM contents alone.

Top module: `nvram_index_port`

## Requirements
- R1: A write to offset 0 replaces pointer bits [7:0] and a write to offset 1 replaces pointer bits [15:8]. In both cases the other half is kept.
- R2: A write to offset 3 stores the data byte at the current pointer. From the next cycle on, the pointer reads as zero.
- R3: A read of offset 3 returns the byte at the pointer on rdData. rdData is registered and valid after the clock edge that samples the read strobe. The read does not change the pointer.
- R4: A read of offset 0, 1 or 2 drives 0xFF on rdData.
- R5: A write to offset 2 changes neither the pointer nor any RAM byte.
- R6: While protection bit 0 is set, locations 0x20..0x2F ignore writes and read as 0xFF. Bit 1 does the same for 0x30..0x3F. Other locations are unaffected.
- R7: A cycle with lockTgl high inverts protection bit lockIdx (0 or 1) and leaves the other bit unchanged.
- R8: Reset clears the pointer and both protection bits and sets rdData to 0xFF. RAM contents survive reset.
- R9: A pointer at or above MEM_BYTES (256 by default) ignores writes, with no aliasing onto lower locations, and reads as 0xFF.
- R10: A data write that is dropped by protection or by range still clears the pointer to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accStb | input | 1 | One-cycle access strobe for the window |
| accWr | input | 1 | 1 = write, 0 = read, qualified by accStb |
| accOff | input | 2 | Window offset: 0 pointer low, 1 pointer high, 2 unused, 3 data |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Registered read byte |
| lockTgl | input | 1 | One-cycle pulse that flips one protection bit |
| lockIdx | input | 1 | Selects which protection bit lockTgl flips |

## Verification
The hardest behaviour to reach from the ports is the pointer's own state. It can only be observed indirectly, through which location a later data transfer touches. The stimulus therefore chains transfers. It makes a second data write without reloading the pointer and reads back location zero. It loads only one pointer half and reads at the combined address. It issues a reset while a pointer is loaded and reads offset 3 straight away. The protection windows are swept with every combination of the two bits. Each sweep first writes through the protected range and then reads a span that overlaps both window edges, which exposes off-by-one boundaries and any write that was not blocked.

// File: rtl/nvram_port_pkg.sv
package nvram_port_pkg;

  typedef enum logic [1:0] {
    OFF_PTR_LO = 2'd0,
    OFF_PTR_HI = 2'd1,
    OFF_UNUSED = 2'd2,
    OFF_DATA   = 2'd3
  } portOff_e;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic loadLo;     // pointer low byte <- wrData
    logic loadHi;     // pointer high byte <- wrData
    logic clearPtr;   // pointer <- 0 (every data write)
    logic memWrite;   // RAM[pointer] <- wrData (permitted writes only)
    logic memRead;    // rdData <- RAM[pointer]
    logic forceOnes;  // rdData <- all ones
  } ctrlStb_t;

endpackage

// File: rtl/nvram_lock_guard.sv
module nvram_lock_guard #(
  parameter int ADDR_W    = 16,
  parameter int NUM_LOCKS = 2,
  parameter int LOCK_BASE = 32,
  parameter int LOCK_SPAN = 16
) (
  input  logic [ADDR_W-1:0]    curAddr,
  input  logic [NUM_LOCKS-1:0] lockState,
  output logic                 blocked
);

  logic [NUM_LOCKS-1:0] winHit;

  // One comparator pair per protected window, windows laid end to end
  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_win
    localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(LOCK_BASE + i * LOCK_SPAN);
    localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(LOCK_BASE + (i + 1) * LOCK_SPAN);
    logic inWin;
    assign inWin     = ({1'b0, curAddr} >= WIN_LO) && ({1'b0, curAddr} < WIN_HI);
    assign winHit[i] = lockState[i] && inWin;
  end

  assign blocked = |winHit;

endmodule

// File: rtl/nvram_port_ctrl.sv
module nvram_port_ctrl
  import nvram_port_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int MEM_BYTES  = 256,
  parameter int NUM_LOCKS  = 2,
  parameter int LOCK_BASE  = 32,
  parameter int LOCK_SPAN  = 16,
  parameter int LOCK_IDX_W = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  accStb,
  input  logic                  accWr,
  input  logic [1:0]            accOff,
  input  logic                  lockTgl,
  input  logic [LOCK_IDX_W-1:0] lockIdx,
  input  logic [ADDR_W-1:0]     curAddr,
  output ctrlStb_t              stb,
  output logic [NUM_LOCKS-1:0]  lockState
);

  localparam logic [ADDR_W:0] MEM_LIMIT = (ADDR_W+1)'(MEM_BYTES);

  logic [NUM_LOCKS-1:0] lockQ;
  logic blocked;
  logic inRange;
  logic permitted;
  logic isData;

  nvram_lock_guard #(
    .ADDR_W   (ADDR_W),
    .NUM_LOCKS(NUM_LOCKS),
    .LOCK_BASE(LOCK_BASE),
    .LOCK_SPAN(LOCK_SPAN)
  ) u_guard (
    .curAddr  (curAddr),
    .lockState(lockQ),
    .blocked  (blocked)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ <= '0;
    end else if (lockTgl) begin
      lockQ <= lockQ ^ (NUM_LOCKS'(1) << lockIdx);
    end
  end

  assign lockState = lockQ;
  assign inRange   = {1'b0, curAddr} < MEM_LIMIT;
  assign permitted = inRange && !blocked;
  assign isData    = accStb && (accOff == OFF_DATA);

  always_comb begin
    stb           = '0;
    stb.loadLo    = accStb && accWr && (accOff == OFF_PTR_LO);
    stb.loadHi    = accStb && accWr && (accOff == OFF_PTR_HI);
    stb.clearPtr  = isData && accWr;
    stb.memWrite  = isData && accWr && permitted;
    stb.memRead   = isData && !accWr && permitted;
    stb.forceOnes = accStb && !accWr && !(isData && permitted);
  end

  // R7
  lock_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockTgl |=> $countones(lockState ^ $past(lockState)) == 1);

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lockTgl |=> $stable(lockState));

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadLo, stb.loadHi, stb.clearPtr, stb.memRead, stb.forceOnes}));

  // R6
  blocked_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    blocked |-> !stb.memWrite && !stb.memRead);

endmodule

// File: rtl/nvram_port_dpath.sv
module nvram_port_dpath
  import nvram_port_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 16,
  parameter int MEM_BYTES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] curAddr
);

  localparam int MEM_AW = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1;

  logic [ADDR_W-1:0] ptrQ;
  logic [DATA_W-1:0] rdQ;
  logic [DATA_W-1:0] mem [MEM_BYTES];
  logic [MEM_AW-1:0] memIdx;

  assign memIdx = ptrQ[MEM_AW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (stb.clearPtr) begin
      ptrQ <= '0;
    end else if (stb.loadLo) begin
      ptrQ[DATA_W-1:0] <= wrData;
    end else if (stb.loadHi) begin
      ptrQ[ADDR_W-1:DATA_W] <= wrData;
    end
  end

  // RAM contents keep their value across reset
  always_ff @(posedge clk) begin
    if (stb.memWrite) begin
      mem[memIdx] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ <= '1;
    end else if (stb.forceOnes) begin
      rdQ <= '1;
    end else if (stb.memRead) begin
      rdQ <= mem[memIdx];
    end
  end

  assign rdData  = rdQ;
  assign curAddr = ptrQ;

  // R1
  lo_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadLo |=> ptrQ[DATA_W-1:0] == $past(wrData)
                   && ptrQ[ADDR_W-1:DATA_W] == $past(ptrQ[ADDR_W-1:DATA_W]));

  // R1
  hi_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadHi |=> ptrQ[ADDR_W-1:DATA_W] == $past(wrData)
                   && ptrQ[DATA_W-1:0] == $past(ptrQ[DATA_W-1:0]));

  // R3
  read_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.memRead && !stb.forceOnes |=> $stable(rdQ));

endmodule

// File: rtl/nvram_index_port.sv
module nvram_index_port
  import nvram_port_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  parameter int NUM_LOCKS = 2,
  parameter int LOCK_BASE = 32,
  parameter int LOCK_SPAN = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       accStb,
  input  logic       accWr,
  input  logic [1:0] accOff,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       lockTgl,
  input  logic       lockIdx
);

  localparam int DATA_W = 8;
  localparam int ADDR_W = 2 * DATA_W;

  ctrlStb_t             stb;
  logic [ADDR_W-1:0]    curAddr;
  logic [NUM_LOCKS-1:0] lockState;

  nvram_port_ctrl #(
    .ADDR_W    (ADDR_W),
    .MEM_BYTES (MEM_BYTES),
    .NUM_LOCKS (NUM_LOCKS),
    .LOCK_BASE (LOCK_BASE),
    .LOCK_SPAN (LOCK_SPAN),
    .LOCK_IDX_W(1)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .accStb   (accStb),
    .accWr    (accWr),
    .accOff   (accOff),
    .lockTgl  (lockTgl),
    .lockIdx  (lockIdx),
    .curAddr  (curAddr),
    .stb      (stb),
    .lockState(lockState)
  );

  nvram_port_dpath #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .MEM_BYTES(MEM_BYTES)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (wrData),
    .rdData (rdData),
    .curAddr(curAddr)
  );

  // R2
  data_wr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    accStb && accWr && accOff == 2'd3 |=> curAddr == '0);

  // R3
  data_rd_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    accStb && !accWr && accOff == 2'd3 |=> $stable(curAddr));

  // R4
  ptr_rd_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    accStb && !accWr && accOff != 2'd3 |=> rdData == 8'hFF);

  // R5
  unused_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    accStb && accWr && accOff == 2'd2 |=> $stable(curAddr));

  // R6
  win0_rd_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    accStb && !accWr && accOff == 2'd3 && lockState[0]
    && curAddr >= ADDR_W'(LOCK_BASE) && curAddr < ADDR_W'(LOCK_BASE + LOCK_SPAN)
    |=> rdData == 8'hFF);

  // R9
  range_rd_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    accStb && !accWr && accOff == 2'd3 && {1'b0, curAddr} >= (ADDR_W+1)'(MEM_BYTES)
    |=> rdData == 8'hFF);

endmodule

// File: tb/tb_nvram_index_port.sv
module tb_nvram_index_port;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       accStb = 1'b0;
  logic       accWr = 1'b0;
  logic [1:0] accOff = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       lockTgl = 1'b0;
  logic       lockIdx = 1'b0;

  int compared = 0;
  int mismatched = 0;

  logic [7:0] model [256];
  logic [1:0] lk = 2'b00;

  always #2 clk = ~clk;

  nvram_index_port dut (
    .clk(clk), .rstN(rstN), .accStb(accStb), .accWr(accWr), .accOff(accOff),
    .wrData(wrData), .rdData(rdData), .lockTgl(lockTgl), .lockIdx(lockIdx)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  function automatic bit isBlocked(input int a);
    return (a >= 256) || (lk[0] && a >= 32 && a < 48)
           || (lk[1] && a >= 48 && a < 64);
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] off, input logic [7:0] d);
    @(negedge clk);
    accStb = 1'b1; accWr = 1'b1; accOff = off; wrData = d;
    @(negedge clk);
    accStb = 1'b0; accWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] off, output logic [7:0] d);
    @(negedge clk);
    accStb = 1'b1; accWr = 1'b0; accOff = off;
    @(negedge clk);
    accStb = 1'b0;
    d = rdData;
  endtask

  task automatic setPtr(input int a);
    busWrite(2'd0, 8'(a & 255));
    busWrite(2'd1, 8'((a >> 8) & 255));
  endtask

  // Store at address a, keeping the bench model in step
  task automatic storeAt(input int a, input logic [7:0] d);
    setPtr(a);
    busWrite(2'd3, d);
    if (!isBlocked(a)) model[a] = d;
  endtask

  task automatic expectAt(input string tag, input int a);
    logic [7:0] got;
    setPtr(a);
    busRead(2'd3, got);
    check(tag, got, isBlocked(a) ? 8'hFF : model[a]);
  endtask

  task automatic toggleLock(input int idx);
    @(negedge clk);
    lockTgl = 1'b1; lockIdx = idx[0];
    @(negedge clk);
    lockTgl = 1'b0;
    lk[idx] = ~lk[idx];
  endtask

  task automatic lockSweep(input string tag, input logic [7:0] xorv);
    for (int a = 32; a < 64; a++) storeAt(a, pat(a) ^ xorv);
    for (int a = 24; a < 72; a++) expectAt(tag, a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0] got;
    logic [7:0] got2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R8: reset value of the read register
    check("R8 rdData after reset", rdData, 8'hFF);

    // R4: non-data offsets read as ones
    for (int o = 0; o < 3; o++) begin
      busRead(2'(o), got);
      check("R4 non-data read", got, 8'hFF);
    end

    // R2 / R3: full sweep, write every location then read back
    for (int a = 0; a < 256; a++) storeAt(a, pat(a));
    for (int a = 0; a < 256; a++) expectAt("R3 sweep readback", a);

    // R2: second data write lands at zero without reloading the pointer
    setPtr(16'h0045);
    busWrite(2'd3, 8'hA5); model[16'h45] = 8'hA5;
    busWrite(2'd3, 8'h5A); model[0] = 8'h5A;
    expectAt("R2 first write kept", 16'h45);
    expectAt("R2 write after clear hits zero", 0);

    // R1: reload only the low half, then only the high half
    setPtr(16'h0012);
    busWrite(2'd0, 8'h34);
    busRead(2'd3, got);
    check("R1 low half replaced", got, model[16'h34]);
    busWrite(2'd1, 8'h01);
    busRead(2'd3, got);
    check("R1 high half replaced", got, 8'hFF);
    busWrite(2'd1, 8'h00);
    busRead(2'd3, got);
    check("R1 low half kept", got, model[16'h34]);

    // R3: back-to-back reads keep the pointer
    setPtr(16'h0077);
    busRead(2'd3, got);
    busRead(2'd3, got2);
    check("R3 first read", got, model[16'h77]);
    check("R3 pointer kept on read", got2, model[16'h77]);

    // R5: offset 2 write touches neither pointer nor RAM
    setPtr(16'h0010);
    busWrite(2'd2, 8'h77);
    busRead(2'd3, got);
    check("R5 unused offset write", got, model[16'h10]);

    // R6 / R7: every protection combination
    lockSweep("R6 no locks", 8'h00);
    toggleLock(0);
    lockSweep("R6 lock0 only", 8'hFF);
    toggleLock(1);
    lockSweep("R7 both locks", 8'h3C);
    toggleLock(0);
    lockSweep("R7 lock1 only", 8'hC3);
    toggleLock(0);

    // R8: reset with both locks set and a pointer loaded
    setPtr(16'h0033);
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    lk = 2'b00;
    check("R8 rdData after second reset", rdData, 8'hFF);
    busRead(2'd3, got);
    check("R8 pointer cleared by reset", got, model[0]);
    expectAt("R8 locks cleared, RAM kept", 16'h25);
    expectAt("R8 locks cleared, RAM kept", 16'h3A);

    // R9: out-of-range pointers, no aliasing
    for (int h = 1; h < 256; h += 127) begin
      for (int l = 0; l < 256; l += 85) begin
        storeAt((h << 8) | l, 8'hEE);
        expectAt("R9 out of range read", (h << 8) | l);
        expectAt("R9 no alias", l);
      end
    end

    // R10: dropped writes still clear the pointer
    setPtr(16'h0123);
    busWrite(2'd3, 8'h11);
    busWrite(2'd3, 8'h66); model[0] = 8'h66;
    expectAt("R10 clear after range drop", 0);
    toggleLock(1);
    setPtr(16'h0035);
    busWrite(2'd3, 8'h22);
    busWrite(2'd3, 8'h99); model[0] = 8'h99;
    expectAt("R10 clear after lock drop", 0);
    expectAt("R10 locked location", 16'h35);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule